// File: doc/BRIEF.md
# Byte-Valid Write-Allocate Line Buffer

This block holds one 128-bit line of a write-back cache and keeps a valid bit for each of its sixteen bytes. A processor write to a line that is not held claims the line at once, with no memory read. The bytes selected by the lane enables are stored and marked valid. Later writes to the same line add more bytes. A zero command fills the whole line with zeros and marks every byte valid, also with no read.

Memory is read only when it is needed. If a processor read finds any byte invalid, the block fetches the line, keeps the valid bytes it already holds, and takes the rest from memory. On eviction, a line with every byte valid goes straight to memory as one full-line write. A line with gaps is first fetched and merged, then written back whole. An eviction happens on a flush command, or when a request names a different line address than the one held. A request that forces an eviction is kept inside the block and carried out once the writeback has finished.

Top module: `wa_line_buf`

## Requirements
- R1: After reset, `cpu_ready` is high, `cpu_rvalid`, `mem_rd_valid` and `mem_wr_valid` are low, and no line is held. A flush then causes no memory traffic.
- R2: A write (`cpu_op` = 1) to a line that is not held allocates it without any memory read. The enabled bytes become valid.
- R3: Writes that hit the held line change only the byte lanes whose `cpu_be` bit is set (byte i is `cpu_wdata[8i+7:8i]`). Later writes override earlier ones lane by lane.
- R4: A flush (`cpu_op` = 3) of a held line with all sixteen bytes valid produces exactly one memory write of the stored line at its line address, and no read.
- R5: A flush of a held line with any byte invalid issues one read of the line address. It then writes back a line whose valid bytes come from the buffer and whose other bytes come from the read data.
- R6: A zero command (`cpu_op` = 2) leaves the line all zeros with every byte valid, and issues no read. A following flush writes 128 zero bits with no read.
- R7: A read (`cpu_op` = 0) of a held line whose bytes are all valid returns the line with `cpu_rvalid` high in the cycle after acceptance, with no memory traffic.
- R8: A read of a held line with some invalid bytes fetches the line once and returns the merged line. After that, all bytes are valid, so a flush needs no read.
- R9: A read of a line address that is not held allocates it and returns the line read from memory.
- R10: A write, read or zero to a different line address than the held one first evicts the held line to its own address, as in R4/R5. The new request is then applied and not lost.
- R11: `cpu_ready` is low whenever a memory request is outstanding. A memory request with valid high and ready low keeps valid, address and data unchanged in the next cycle.
- R12: After a writeback completes, no line is held: a following flush causes no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted when high together with valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 zero line, 3 flush |
| cpu_line_addr | input | TAG_W (28) | Line address of the request |
| cpu_wdata | input | 128 | Write data, byte i in bits 8i+7:8i |
| cpu_be | input | 16 | Per-byte write enables |
| cpu_rvalid | output | 1 | Read data valid, one-cycle pulse |
| cpu_rdata | output | 128 | Read data |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | TAG_W (28) | Line address to read |
| mem_rdata_valid | input | 1 | Memory read data valid |
| mem_rdata_ready | output | 1 | Block is waiting for read data |
| mem_rdata | input | 128 | Memory read data |
| mem_wr_valid | output | 1 | Memory full-line write valid |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | TAG_W (28) | Line address to write |
| mem_wr_data | output | 128 | Full line write data |

## Verification
The hardest case to reach is a request to a new line address that arrives while a held line still has invalid bytes. It takes an eviction fill, a merge, a writeback, and then the held request applied on top of a freshly emptied line, all under memory back-pressure. The stimulus reaches it with a directed single-byte write followed by a write elsewhere. Random traffic then cycles through only three line addresses with random lane enables, so mismatched requests to partially valid lines happen often. The memory model answers with random ready gaps and read latency.

// File: rtl/wa_line_pkg.sv
package wa_line_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ZERO  = 2'd2,
        OP_FLUSH = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ACTIVE    = 3'd1,
        ST_FILL_REQ  = 3'd2,
        ST_FILL_WAIT = 3'd3,
        ST_MERGE     = 3'd4,
        ST_WB_REQ    = 3'd5,
        ST_DONE      = 3'd6
    } state_e;

endpackage

// File: rtl/wa_lane_mux.sv
module wa_lane_mux #(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0]   sel,
    input  logic [LANES*8-1:0] a,
    input  logic [LANES*8-1:0] b,
    output logic [LANES*8-1:0] y
);
    // Per-byte select: lane taken from a when its select bit is set, else from b.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign y[i*8 +: 8] = sel[i] ? a[i*8 +: 8] : b[i*8 +: 8];
    end
endmodule

// File: rtl/wa_all_set.sv
module wa_all_set #(
    parameter int N = 16
) (
    input  logic [N-1:0] v,
    output logic         all
);
    assign all = &v;
endmodule

// File: rtl/wa_line_buf.sv
module wa_line_buf
    import wa_line_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int TAG_W      = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic [1:0]              cpu_op,
    input  logic [TAG_W-1:0]        cpu_line_addr,
    input  logic [LINE_BYTES*8-1:0] cpu_wdata,
    input  logic [LINE_BYTES-1:0]   cpu_be,
    output logic                    cpu_rvalid,
    output logic [LINE_BYTES*8-1:0] cpu_rdata,
    output logic                    mem_rd_valid,
    input  logic                    mem_rd_ready,
    output logic [TAG_W-1:0]        mem_rd_addr,
    input  logic                    mem_rdata_valid,
    output logic                    mem_rdata_ready,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    output logic                    mem_wr_valid,
    input  logic                    mem_wr_ready,
    output logic [TAG_W-1:0]        mem_wr_addr,
    output logic [LINE_BYTES*8-1:0] mem_wr_data
);
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        state_e                st;
        logic                  present;
        logic [TAG_W-1:0]      tag;
        logic [LINE_W-1:0]     data;
        logic [LINE_BYTES-1:0] vld;
        logic [LINE_W-1:0]     fill;
        logic                  fill_rd;   // fill serves a processor read (else an eviction)
        logic                  pend;      // a request waits for the eviction to finish
        op_e                   pop;
        logic [TAG_W-1:0]      ptag;
        logic [LINE_W-1:0]     pdata;
        logic [LINE_BYTES-1:0] pbe;
        logic                  rvalid;
    } regs_t;

    regs_t r_d, r_q;

    logic                  cpu_fire, use_pend, eff_go, eff_present, hit, all_valid;
    op_e                   eff_op;
    logic [TAG_W-1:0]      eff_tag;
    logic [LINE_W-1:0]     eff_data, wr_merged, fill_merged;
    logic [LINE_BYTES-1:0] eff_be, base_vld;

    assign cpu_ready       = (r_q.st == ST_IDLE) || (r_q.st == ST_ACTIVE);
    assign cpu_fire        = cpu_valid && cpu_ready;
    assign use_pend        = (r_q.st == ST_DONE) && r_q.pend;
    assign eff_go          = cpu_fire || use_pend;
    assign eff_op          = use_pend ? r_q.pop   : op_e'(cpu_op);
    assign eff_tag         = use_pend ? r_q.ptag  : cpu_line_addr;
    assign eff_data        = use_pend ? r_q.pdata : cpu_wdata;
    assign eff_be          = use_pend ? r_q.pbe   : cpu_be;
    assign eff_present     = use_pend ? 1'b0      : r_q.present;
    assign hit             = eff_present && (r_q.tag == eff_tag);
    assign base_vld        = eff_present ? r_q.vld : '0;

    assign cpu_rvalid      = r_q.rvalid;
    assign cpu_rdata       = r_q.data;
    assign mem_rd_valid    = (r_q.st == ST_FILL_REQ);
    assign mem_rd_addr     = r_q.tag;
    assign mem_rdata_ready = (r_q.st == ST_FILL_WAIT);
    assign mem_wr_valid    = (r_q.st == ST_WB_REQ);
    assign mem_wr_addr     = r_q.tag;
    assign mem_wr_data     = r_q.data;

    wa_lane_mux #(.LANES(LINE_BYTES)) u_wr_mux (
        .sel(eff_be), .a(eff_data), .b(r_q.data), .y(wr_merged)
    );

    wa_lane_mux #(.LANES(LINE_BYTES)) u_fill_mux (
        .sel(r_q.vld), .a(r_q.data), .b(r_q.fill), .y(fill_merged)
    );

    wa_all_set #(.N(LINE_BYTES)) u_all (
        .v(r_q.vld), .all(all_valid)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_ACTIVE, ST_DONE: begin
                if (r_q.st == ST_DONE) begin
                    r_d.present = 1'b0;
                    r_d.vld     = '0;
                    r_d.pend    = 1'b0;
                    r_d.st      = ST_IDLE;
                end
                if (eff_go) begin
                    if (eff_op == OP_FLUSH || (eff_present && !hit)) begin
                        if (eff_present) begin
                            if (eff_op != OP_FLUSH) begin
                                r_d.pend  = 1'b1;
                                r_d.pop   = eff_op;
                                r_d.ptag  = eff_tag;
                                r_d.pdata = eff_data;
                                r_d.pbe   = eff_be;
                            end
                            r_d.fill_rd = 1'b0;
                            r_d.st      = all_valid ? ST_WB_REQ : ST_FILL_REQ;
                        end
                    end else begin
                        r_d.present = 1'b1;
                        r_d.tag     = eff_tag;
                        r_d.st      = ST_ACTIVE;
                        unique case (eff_op)
                            OP_WRITE: begin
                                r_d.data = wr_merged;
                                r_d.vld  = base_vld | eff_be;
                            end
                            OP_ZERO: begin
                                r_d.data = '0;
                                r_d.vld  = '1;
                            end
                            default: begin
                                r_d.vld = base_vld;
                                if (&base_vld) begin
                                    r_d.rvalid = 1'b1;
                                end else begin
                                    r_d.fill_rd = 1'b1;
                                    r_d.st      = ST_FILL_REQ;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_FILL_REQ: begin
                if (mem_rd_ready) r_d.st = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (mem_rdata_valid) begin
                    r_d.fill = mem_rdata;
                    r_d.st   = ST_MERGE;
                end
            end
            ST_MERGE: begin
                r_d.data = fill_merged;
                r_d.vld  = '1;
                if (r_q.fill_rd) begin
                    r_d.rvalid = 1'b1;
                    r_d.st     = ST_ACTIVE;
                end else begin
                    r_d.st = ST_WB_REQ;
                end
            end
            ST_WB_REQ: begin
                if (mem_wr_ready) r_d.st = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.pop     <= OP_READ;
        end else begin
            r_q <= r_d;
        end
    end

    // A full-line write only ever leaves with every byte resolved.
    assert_wr_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (&r_q.vld));

    // A flush of a completely valid line goes straight to the write channel.
    assert_full_skip_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_fire && cpu_op == OP_FLUSH && r_q.present && (&r_q.vld)) |=> mem_wr_valid);

    // Zero command on an absent or matching line yields an all-zero, all-valid line.
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_fire && cpu_op == OP_ZERO && (!r_q.present || r_q.tag == cpu_line_addr))
        |=> ((&r_q.vld) && r_q.data == '0 && !mem_rd_valid));

    // Read data is only returned once every byte is valid.
    assert_read_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (&r_q.vld));

    // Pending memory requests hold still until accepted.
    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_addr)));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // After a writeback with nothing waiting, the buffer is empty.
    assert_empty_after_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE && !r_q.pend) |=> (!r_q.present && r_q.vld == '0));

endmodule

// File: tb/sim_wa_line_buf.sv
module sim_wa_line_buf;
    localparam int TAG_W = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0;
    logic         cpu_ready;
    logic [1:0]   cpu_op = 2'd0;
    logic [TAG_W-1:0] cpu_line_addr = '0;
    logic [127:0] cpu_wdata = '0;
    logic [15:0]  cpu_be = '0;
    logic         cpu_rvalid;
    logic [127:0] cpu_rdata;
    logic         mem_rd_valid;
    logic         mem_rd_ready = 1'b0;
    logic [TAG_W-1:0] mem_rd_addr;
    logic         mem_rdata_valid = 1'b0;
    logic         mem_rdata_ready;
    logic [127:0] mem_rdata = '0;
    logic         mem_wr_valid;
    logic         mem_wr_ready = 1'b0;
    logic [TAG_W-1:0] mem_wr_addr;
    logic [127:0] mem_wr_data;

    always #5 clk = ~clk;

    wa_line_buf u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
        .cpu_line_addr(cpu_line_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata_ready(mem_rdata_ready), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // memory model
    logic [127:0] mem_model [logic [TAG_W-1:0]];
    int rd_count = 0, wr_count = 0;
    logic [TAG_W-1:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [127:0] last_wr_data = '0;

    // bench reference of the buffer
    bit           ref_present = 0;
    logic [TAG_W-1:0] ref_tag = '0;
    logic [127:0] ref_data = '0;
    logic [15:0]  ref_vld = '0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pattern(input logic [TAG_W-1:0] a);
        logic [31:0] w;
        w = {4'h0, a};
        return {w * 32'h9E3779B1, ~w, w ^ 32'h5A5A1234, w + 32'h1357};
    endfunction

    function automatic logic [127:0] mem_line(input logic [TAG_W-1:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return pattern(a);
    endfunction

    function automatic logic [127:0] bmerge(input logic [15:0] sel, input logic [127:0] a, input logic [127:0] b);
        logic [127:0] y;
        for (int i = 0; i < 16; i++) y[i*8 +: 8] = sel[i] ? a[i*8 +: 8] : b[i*8 +: 8];
        return y;
    endfunction

    // memory responder: decides readies at the negedge, handshakes land at the next posedge
    initial begin
        bit pw = 0, pr = 0;
        logic [127:0] pw_data = '0;
        logic [TAG_W-1:0] pw_addr = '0, pr_addr = '0, resp_addr = '0;
        int resp_cnt = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (pw) chk(mem_wr_valid && mem_wr_data == pw_data && mem_wr_addr == pw_addr,
                        "R11 write request held", mem_wr_data, pw_data);
            if (pr) chk(mem_rd_valid && mem_rd_addr == pr_addr,
                        "R11 read request held", {100'd0, mem_rd_addr}, {100'd0, pr_addr});
            if (mem_rd_valid || mem_wr_valid)
                chk(!cpu_ready, "R11 stalled while memory busy", {127'd0, cpu_ready}, 128'd0);
            if (mem_rdata_valid) mem_rdata_valid = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    mem_rdata       = mem_line(resp_addr);
                    mem_rdata_valid = 1'b1;
                end
            end
            mem_rd_ready = ($urandom % 3) != 0;
            mem_wr_ready = ($urandom % 3) != 0;
            if (mem_rd_valid && mem_rd_ready) begin
                rd_count++;
                last_rd_addr = mem_rd_addr;
                resp_addr    = mem_rd_addr;
                resp_cnt     = 1 + ($urandom % 3);
            end
            if (mem_wr_valid && mem_wr_ready) begin
                wr_count++;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
                mem_model[mem_wr_addr] = mem_wr_data;
            end
            pw = mem_wr_valid && !mem_wr_ready;
            pw_data = mem_wr_data;
            pw_addr = mem_wr_addr;
            pr = mem_rd_valid && !mem_rd_ready;
            pr_addr = mem_rd_addr;
        end
    end

    // one processor request, with its expected outcome computed from the requirements
    task automatic run(input logic [1:0] op, input logic [TAG_W-1:0] a,
                       input logic [127:0] wd, input logic [15:0] be);
        int rd0, wr0, exp_rd, exp_wr, lat, rv_lat;
        bit hitm, evict, got_rv;
        logic [TAG_W-1:0] exp_waddr;
        logic [127:0] exp_wdata, exp_rdata, got_rdata;
        string tg;
        rd0 = rd_count; wr0 = wr_count;
        exp_rd = 0; exp_wr = 0; exp_waddr = '0; exp_wdata = '0; exp_rdata = '0;
        tg = "R2";
        hitm  = ref_present && ref_tag == a;
        evict = ref_present && (op == 2'd3 || !hitm);
        if (evict) begin
            exp_wr = 1;
            exp_waddr = ref_tag;
            if (&ref_vld) begin
                exp_wdata = ref_data;
                tg = (op == 2'd3) ? "R4" : "R10";
            end else begin
                exp_rd = 1;
                exp_wdata = bmerge(ref_vld, ref_data, mem_line(ref_tag));
                tg = (op == 2'd3) ? "R5" : "R10";
            end
            ref_present = 0;
            ref_vld = '0;
        end else if (op == 2'd3) begin
            tg = "R12";
        end
        if (op != 2'd3) begin
            if (!ref_present) begin
                ref_present = 1;
                ref_tag = a;
                ref_vld = '0;
            end
            case (op)
                2'd1: begin
                    ref_data = bmerge(be, wd, ref_data);
                    ref_vld  = ref_vld | be;
                    if (!evict) tg = hitm ? "R3" : "R2";
                end
                2'd2: begin
                    ref_data = '0;
                    ref_vld  = '1;
                    if (!evict) tg = "R6";
                end
                default: begin
                    if (!evict) tg = hitm ? ((&ref_vld) ? "R7" : "R8") : "R9";
                    if (!(&ref_vld)) begin
                        exp_rd++;
                        ref_data = bmerge(ref_vld, ref_data, mem_line(a));
                        ref_vld  = '1;
                    end
                    exp_rdata = ref_data;
                end
            endcase
        end
        // drive
        cpu_valid = 1'b1; cpu_op = op; cpu_line_addr = a; cpu_wdata = wd; cpu_be = be;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        lat = 1; got_rv = 0; rv_lat = 0; got_rdata = '0;
        forever begin
            if (cpu_rvalid && !got_rv) begin
                got_rv = 1; rv_lat = lat; got_rdata = cpu_rdata;
            end
            if (cpu_ready && (op != 2'd0 || got_rv)) break;
            @(negedge clk);
            lat++;
        end
        chk(rd_count - rd0 == exp_rd, {tg, " memory read count"},
            128'(rd_count - rd0), 128'(exp_rd));
        chk(wr_count - wr0 == exp_wr, {tg, " memory write count"},
            128'(wr_count - wr0), 128'(exp_wr));
        if (exp_wr == 1) begin
            chk(last_wr_addr == exp_waddr, {tg, " writeback address"},
                {100'd0, last_wr_addr}, {100'd0, exp_waddr});
            chk(last_wr_data == exp_wdata, {tg, " writeback data"}, last_wr_data, exp_wdata);
        end
        if (exp_rd >= 1 && op == 2'd0)
            chk(last_rd_addr == a, {tg, " fill address"}, {100'd0, last_rd_addr}, {100'd0, a});
        if (op == 2'd0) begin
            chk(got_rv && got_rdata == exp_rdata, {tg, " read data"}, got_rdata, exp_rdata);
            if (exp_rd == 0 && exp_wr == 0)
                chk(rv_lat == 1, "R7 read latency one cycle", 128'(rv_lat), 128'd1);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cpu_ready && !cpu_rvalid && !mem_rd_valid && !mem_wr_valid, "R1 reset outputs",
            {124'd0, cpu_ready, cpu_rvalid, mem_rd_valid, mem_wr_valid}, 128'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready && !mem_rd_valid && !mem_wr_valid, "R1 after reset release",
            {126'd0, mem_rd_valid, mem_wr_valid}, 128'd0);
        run(2'd3, 28'h0000100, '0, '0);                        // R1: empty flush, no traffic
        // R2 + R4: full write, then flush with no read
        run(2'd1, 28'h0000100, rnd128(), 16'hFFFF);
        run(2'd3, 28'h0000100, '0, '0);
        // R3 + R5: overlapping partial writes, partial flush
        run(2'd1, 28'h0000100, rnd128(), 16'h00FF);
        run(2'd1, 28'h0000100, rnd128(), 16'h0F0F);
        run(2'd3, 28'h0000100, '0, '0);
        // R6 zero then flush
        run(2'd2, 28'h0000240, '0, '0);
        run(2'd0, 28'h0000240, '0, '0);                        // R7 hit read
        run(2'd3, 28'h0000240, '0, '0);
        // R8 read with holes, then flush with no read
        run(2'd1, 28'h00003C0, rnd128(), 16'hF000);
        run(2'd0, 28'h00003C0, '0, '0);
        run(2'd3, 28'h00003C0, '0, '0);
        // R9 read absent line
        run(2'd0, 28'h0000555, '0, '0);
        // R10 write to other line while a partial line is held
        run(2'd1, 28'h0000100, rnd128(), 16'h0001);
        run(2'd1, 28'h0000240, rnd128(), 16'hFFFF);
        run(2'd3, 28'h0000240, '0, '0);
        run(2'd3, 28'h0000240, '0, '0);                        // R12 empty after writeback
        // constrained random traffic over three line addresses
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op;
            logic [15:0] be;
            int sel;
            sel = $urandom % 10;
            op  = (sel < 5) ? 2'd1 : (sel < 7) ? 2'd0 : (sel < 8) ? 2'd2 : 2'd3;
            be  = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
            case ($urandom % 3)
                0: run(op, 28'h0000100, rnd128(), be);
                1: run(op, 28'h0000240, rnd128(), be);
                default: run(op, 28'h00003C0, rnd128(), be);
            endcase
        end
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule